// File: doc/BRIEF.md
# I/Q Serial Receive Port Generator

This block produces the receive-side serial port of a baseband codec from a master clock. When receive power-up is requested, it holds the port clocks idle for a settling interval. The length of that interval depends on whether offset autocalibration is selected. After the interval it runs a bit clock at one quarter of the master clock rate and a frame strobe once every sixteen bit periods. It shifts out one sample per frame on a serial data line.

Each frame holds a 15-bit sample, most significant bit first, followed by a marker bit that tells the receiver whether the sample was in-phase or quadrature. Frames alternate I, Q, I, Q and always start with I after power-up. A parallel I/Q pair is taken from the inputs at the start of every I frame when it is offered as valid. When no pair is offered, the last pair is sent again. Every serial output has its own three-state enable, driven from a registered output-enable control.

Top module: `iqrx_port`

## Requirements
- R1: While reset is asserted (asynchronous, active low), all three enables, the bit clock, the frame strobe, serial data and the acknowledge are 0. After reset is released and before power-up is requested, the clocks and strobe stay at 0.
- R2: With calibration selected (cal_on=1), the first bit-clock high comes exactly 10240 master clocks after the edge that first samples pwr_en=1. The bit clock is 0 during every cycle before that.
- R3: With calibration not selected (cal_on=0), the same interval is exactly 6144 master clocks.
- R4: While running, the bit clock repeats with a period of 4 master clocks: high for 2, then low for 2.
- R5: The frame strobe has a period of 64 master clocks and stays high for 4 master clocks. It goes high in the same cycle as a bit-clock rise.
- R6: Serial data changes only in cycles where the bit clock rises. Each frame is 16 bits: sample bits 14 down to 0, then the marker bit. The marker is 1 for an I sample and 0 for a Q sample.
- R7: The first frame after power-up carries I, and later frames alternate strictly between Q and I.
- R8: pair_ack pulses for one cycle in the last master clock before each I frame starts, and only when pair_valid is 1. At that edge pair_i and pair_q are captured. With pair_valid=0, the previous pair is sent again and the input data has no effect.
- R9: The three enables equal out_en as sampled on the previous master-clock edge. When out_en=0, all three enables are 0, even while the port is running.
- R10: When pwr_en=0 is sampled, the bit clock and frame strobe are 0 from the following cycle on. A later request starts the full idle interval again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_en | input | 1 | Receive power-up request, level |
| cal_on | input | 1 | Selects the longer idle interval used with autocalibration |
| out_en | input | 1 | Output-enable control for the three serial pins |
| pair_i | input | 15 | In-phase sample |
| pair_q | input | 15 | Quadrature sample |
| pair_valid | input | 1 | A new pair is offered |
| pair_ack | output | 1 | Pair taken at this edge |
| bclk | output | 1 | Serial bit clock |
| bclk_oe | output | 1 | Three-state enable for bclk |
| fs | output | 1 | Frame strobe |
| fs_oe | output | 1 | Three-state enable for fs |
| sdata | output | 1 | Serial sample data |
| sdata_oe | output | 1 | Three-state enable for sdata |

## Verification
The idle interval is measured from the edge that samples the request to the first cycle in which the bit clock reads high. It must equal the configured count exactly, because the counter loads on that edge and the run state begins as the counter expires. Serial bits and the strobe are sampled half a clock after each bit-clock rise, every fourth master clock from the start of a frame. The acknowledge is looked for in the third cycle after the final bit of a Q frame begins. The enables are checked one cycle after out_en changes, and the quiet state one cycle after pwr_en falls. All inputs are driven and all outputs sampled on the falling edge, so no result depends on the order of processes at the rising edge.

// File: rtl/iqrx_pkg.sv
package iqrx_pkg;
  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_WAIT = 2'd1,
    PWR_RUN  = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/iqrx_powerup.sv
module iqrx_powerup
  import iqrx_pkg::*;
#(
  parameter int CAL_IDLE   = 10240,
  parameter int NOCAL_IDLE = 6144
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_req,
  input  logic cal_on,
  output logic run,
  output logic start
);
  localparam int MAXD = (CAL_IDLE > NOCAL_IDLE) ? CAL_IDLE : NOCAL_IDLE;
  localparam int CW   = $clog2(MAXD + 1);

  pwr_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PWR_OFF: begin
        if (pwr_req) begin
          st_d  = PWR_WAIT;
          cnt_d = cal_on ? CW'(CAL_IDLE - 1) : CW'(NOCAL_IDLE - 1);
        end
      end
      PWR_WAIT: begin
        if (!pwr_req)          st_d = PWR_OFF;
        else if (cnt_q == '0)  st_d = PWR_RUN;
        else                   cnt_d = cnt_q - 1'b1;
      end
      PWR_RUN: begin
        if (!pwr_req) st_d = PWR_OFF;
      end
      default: st_d = PWR_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PWR_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign run   = (st_q == PWR_RUN);
  assign start = (st_q == PWR_WAIT) && pwr_req && (cnt_q == '0);

  // R2 / R3: the port only starts once the idle count has expired
  assert_idle_expired_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run)) |-> ($past(cnt_q) == '0 && $past(st_q) == PWR_WAIT));

  // R10: a dropped request always leaves the run state
  assert_drop_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_req |=> !run);
endmodule

// File: rtl/iqrx_clkgen.sv
module iqrx_clkgen #(
  parameter int DIV  = 4,
  parameter int BITS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  output logic [$clog2(BITS)-1:0] bitn,
  output logic                    frame_end,
  output logic                    bclk,
  output logic                    fs
);
  localparam int PW   = $clog2(DIV);
  localparam int BW   = $clog2(BITS);
  localparam int HALF = DIV / 2;

  logic [PW-1:0] ph_q, ph_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          ph_wrap;

  assign ph_wrap = (ph_q == PW'(DIV - 1));

  always_comb begin
    ph_d  = ph_q;
    bit_d = bit_q;
    if (!run) begin
      ph_d  = '0;
      bit_d = '0;
    end else if (ph_wrap) begin
      ph_d  = '0;
      bit_d = (bit_q == BW'(BITS - 1)) ? '0 : bit_q + 1'b1;
    end else begin
      ph_d  = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      bit_q <= '0;
    end else begin
      ph_q  <= ph_d;
      bit_q <= bit_d;
    end
  end

  assign bitn      = bit_q;
  assign frame_end = run && ph_wrap && (bit_q == BW'(BITS - 1));
  assign bclk      = run && (ph_q < PW'(HALF));
  assign fs        = run && (bit_q == '0);

  // R5: strobe rises together with the bit clock
  assert_fs_with_bclk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs) |-> $rose(bclk));

  // R5: a new frame in steady run only follows the end of the previous one
  assert_frame_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && fs && !$past(fs)) |-> $past(frame_end));

  // R4: a falling bit clock in run was high for the two previous cycles
  assert_bclk_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $fell(bclk)) |-> ($past(bclk, 2) && $past(run, 2)));
endmodule

// File: rtl/iqrx_shifter.sv
module iqrx_shifter #(
  parameter int SW   = 15,
  parameter int BITS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    start,
  input  logic                    frame_end,
  input  logic [$clog2(BITS)-1:0] bitn,
  input  logic [SW-1:0]           pair_i,
  input  logic [SW-1:0]           pair_q,
  input  logic                    pair_valid,
  output logic                    pair_ack,
  output logic                    sdata
);
  localparam int BW = $clog2(BITS);

  logic [SW-1:0]   hold_i_q, hold_i_d;
  logic [SW-1:0]   hold_q_q, hold_q_d;
  logic            is_i_q, is_i_d;
  logic            latch;
  logic [BITS-1:0] word;
  logic [BW-1:0]   idx;

  assign latch = start || (frame_end && !is_i_q);

  always_comb begin
    hold_i_d = hold_i_q;
    hold_q_d = hold_q_q;
    is_i_d   = is_i_q;
    if (latch && pair_valid) begin
      hold_i_d = pair_i;
      hold_q_d = pair_q;
    end
    if (start)          is_i_d = 1'b1;
    else if (frame_end) is_i_d = !is_i_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_i_q <= '0;
      hold_q_q <= '0;
      is_i_q   <= 1'b0;
    end else begin
      hold_i_q <= hold_i_d;
      hold_q_q <= hold_q_d;
      is_i_q   <= is_i_d;
    end
  end

  assign word     = is_i_q ? {hold_i_q, 1'b1} : {hold_q_q, 1'b0};
  assign idx      = BW'(BITS - 1) - bitn;
  assign sdata    = run && word[idx];
  assign pair_ack = latch && pair_valid;

  // R8: an offered pair is captured at the latch edge
  assert_pair_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && pair_valid) |=> (hold_i_q == $past(pair_i) && hold_q_q == $past(pair_q)));

  // R8: without a valid pair the held samples do not move
  assert_pair_repeat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch && pair_valid) |=> ($stable(hold_i_q) && $stable(hold_q_q)));

  // R7: first frame is I, later frames alternate
  assert_first_is_i_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> is_i_q);
  assert_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_end) && !$past(start)) |-> (is_i_q != $past(is_i_q)));
endmodule

// File: rtl/iqrx_port.sv
module iqrx_port #(
  parameter int SW         = 15,
  parameter int DIV        = 4,
  parameter int CAL_IDLE   = 10240,
  parameter int NOCAL_IDLE = 6144
) (
  input  logic          mclk,
  input  logic          rst_n,
  input  logic          pwr_en,
  input  logic          cal_on,
  input  logic          out_en,
  input  logic [SW-1:0] pair_i,
  input  logic [SW-1:0] pair_q,
  input  logic          pair_valid,
  output logic          pair_ack,
  output logic          bclk,
  output logic          bclk_oe,
  output logic          fs,
  output logic          fs_oe,
  output logic          sdata,
  output logic          sdata_oe
);
  localparam int BITS = SW + 1;
  localparam int BW   = $clog2(BITS);

  logic [1:0]    rst_sync_q;
  logic          rst_in_n;
  logic          run, start, frame_end;
  logic [BW-1:0] bitn;
  logic          drv_q, drv_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  iqrx_powerup #(
    .CAL_IDLE  (CAL_IDLE),
    .NOCAL_IDLE(NOCAL_IDLE)
  ) u_pwr (
    .clk    (mclk),
    .rst_n  (rst_in_n),
    .pwr_req(pwr_en),
    .cal_on (cal_on),
    .run    (run),
    .start  (start)
  );

  iqrx_clkgen #(
    .DIV (DIV),
    .BITS(BITS)
  ) u_clk (
    .clk      (mclk),
    .rst_n    (rst_in_n),
    .run      (run),
    .bitn     (bitn),
    .frame_end(frame_end),
    .bclk     (bclk),
    .fs       (fs)
  );

  iqrx_shifter #(
    .SW  (SW),
    .BITS(BITS)
  ) u_shf (
    .clk       (mclk),
    .rst_n     (rst_in_n),
    .run       (run),
    .start     (start),
    .frame_end (frame_end),
    .bitn      (bitn),
    .pair_i    (pair_i),
    .pair_q    (pair_q),
    .pair_valid(pair_valid),
    .pair_ack  (pair_ack),
    .sdata     (sdata)
  );

  assign drv_d = out_en;

  always_ff @(posedge mclk or negedge rst_in_n) begin
    if (!rst_in_n) drv_q <= 1'b0;
    else           drv_q <= drv_d;
  end

  assign bclk_oe  = drv_q;
  assign fs_oe    = drv_q;
  assign sdata_oe = drv_q;

  // R9: pins drive only when the control was high on the previous edge
  assert_oe_follows_R9: assert property (@(posedge mclk) disable iff (!rst_in_n)
    bclk_oe |-> $past(out_en));
  assert_oe_release_R9: assert property (@(posedge mclk) disable iff (!rst_in_n)
    $fell(sdata_oe) |-> !$past(out_en));

  // R10: no clock or strobe the cycle after the request is dropped
  assert_quiet_down_R10: assert property (@(posedge mclk) disable iff (!rst_in_n)
    !$past(pwr_en) |-> (!bclk && !fs));

  // R6: data moves only when the bit clock rises (or the port stops)
  assert_data_on_rise_R6: assert property (@(posedge mclk) disable iff (!rst_in_n)
    (run && $past(run) && !$stable(sdata)) |-> $rose(bclk));
endmodule

// File: tb/iqrx_port_test.sv
module iqrx_port_test;
  localparam int SW  = 15;
  localparam int NV  = 6;
  localparam logic [2*SW:0] VEC [0:NV-1] = '{
    {1'b1, 15'h7FFF, 15'h0000},
    {1'b1, 15'h5555, 15'h2AAA},
    {1'b0, 15'h1111, 15'h2222},
    {1'b1, 15'h0001, 15'h4000},
    {1'b0, 15'h7F00, 15'h00FF},
    {1'b1, 15'h1234, 15'h6DCB}
  };

  logic          mclk = 1'b0;
  logic          rst_n, pwr_en, cal_on, out_en, pair_valid;
  logic [SW-1:0] pair_i, pair_q;
  logic          pair_ack, bclk, bclk_oe, fs, fs_oe, sdata, sdata_oe;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  iqrx_port uut (
    .mclk(mclk), .rst_n(rst_n), .pwr_en(pwr_en), .cal_on(cal_on), .out_en(out_en),
    .pair_i(pair_i), .pair_q(pair_q), .pair_valid(pair_valid), .pair_ack(pair_ack),
    .bclk(bclk), .bclk_oe(bclk_oe), .fs(fs), .fs_oe(fs_oe),
    .sdata(sdata), .sdata_oe(sdata_oe)
  );

  always #5 mclk = ~mclk;

  always @(posedge mclk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // starts on the falling edge where bit 0 of a frame is present
  task automatic capture(output logic [15:0] word, output logic [15:0] fmask,
                         output logic ack);
    ack = 1'b0;
    for (int b = 0; b < 16; b++) begin
      word[15-b]  = sdata;
      fmask[15-b] = fs;
      for (int k = 0; k < 4; k++) begin
        @(negedge mclk);
        ack = ack | pair_ack;
      end
    end
  endtask

  task automatic measure_idle(output int n);
    @(posedge mclk);
    @(negedge mclk);
    n = 0;
    while (!bclk && n < 20000) begin
      n = n + 1;
      @(negedge mclk);
    end
  endtask

  initial begin
    logic [15:0]   w, fm;
    logic          ak;
    logic [SW-1:0] exp_i, exp_q;
    logic [7:0]    bpat, fpat;
    int            n, hi;

    rst_n = 1'b0; pwr_en = 1'b0; cal_on = 1'b0; out_en = 1'b0;
    pair_valid = 1'b0; pair_i = '0; pair_q = '0;
    repeat (3) @(negedge mclk);
    // R1: reset state
    check({bclk_oe, fs_oe, sdata_oe, bclk, fs, sdata, pair_ack} == 7'b0, "R1 reset outputs",
          {bclk_oe, fs_oe, sdata_oe, bclk, fs, sdata, pair_ack}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge mclk);
    check({bclk, fs, bclk_oe} == 3'b0, "R1 idle after release", {bclk, fs, bclk_oe}, 0);

    // R9: enables follow out_en one edge later
    out_en = 1'b1;
    @(negedge mclk);
    check({bclk_oe, fs_oe, sdata_oe} == 3'b111, "R9 enable on", {bclk_oe, fs_oe, sdata_oe}, 7);
    out_en = 1'b0;
    @(negedge mclk);
    check({bclk_oe, fs_oe, sdata_oe} == 3'b000, "R9 enable off", {bclk_oe, fs_oe, sdata_oe}, 0);
    out_en = 1'b1;

    // R3: short idle interval
    {pair_valid, pair_i, pair_q} = VEC[0];
    exp_i = VEC[0][2*SW-1:SW];
    exp_q = VEC[0][SW-1:0];
    cal_on = 1'b0; pwr_en = 1'b1;
    measure_idle(n);
    check(n == 6144, "R3 idle without calibration", n, 6144);

    // vector table: one I frame and one Q frame per entry
    for (int v = 0; v < NV; v++) begin
      capture(w, fm, ak);
      check(w == {exp_i, 1'b1}, "R6 R7 I frame", w, {exp_i, 1'b1});
      check(fm == 16'h8000, "R5 strobe on MSB", fm, 16'h8000);
      if (v + 1 < NV) {pair_valid, pair_i, pair_q} = VEC[v+1];
      else            pair_valid = 1'b0;
      capture(w, fm, ak);
      check(w == {exp_q, 1'b0}, "R6 R7 Q frame", w, {exp_q, 1'b0});
      check(ak == pair_valid, "R8 pair_ack", ak, pair_valid);
      if (pair_valid) begin
        exp_i = pair_i;
        exp_q = pair_q;
      end
      pair_valid = 1'b0;
    end

    // R4 / R5: waveform at the start of a frame
    for (int k = 0; k < 8; k++) begin
      bpat[7-k] = bclk;
      fpat[7-k] = fs;
      @(negedge mclk);
    end
    check(bpat == 8'hCC, "R4 bit clock 2 high 2 low", bpat, 8'hCC);
    check(fpat == 8'hF0, "R5 strobe width", fpat, 8'hF0);

    // R9: enables drop while running
    out_en = 1'b0;
    @(negedge mclk);
    check({bclk_oe, fs_oe, sdata_oe} == 3'b000, "R9 off while running",
          {bclk_oe, fs_oe, sdata_oe}, 0);
    out_en = 1'b1;

    // R10: power down
    pwr_en = 1'b0;
    hi = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge mclk);
      hi = hi + int'(bclk) + int'(fs);
    end
    check(hi == 0, "R10 quiet after power down", hi, 0);

    // R2: long idle interval; first frame repeats the held pair (R8) as I (R7)
    pair_i = 15'h0AAA; pair_q = 15'h0555; pair_valid = 1'b0;
    cal_on = 1'b1; pwr_en = 1'b1;
    measure_idle(n);
    check(n == 10240, "R2 idle with calibration", n, 10240);
    capture(w, fm, ak);
    check(w == {exp_i, 1'b1}, "R7 R8 first frame repeats held I", w, {exp_i, 1'b1});
    capture(w, fm, ak);
    check(w == {exp_q, 1'b0}, "R8 held Q ignores input data", w, {exp_q, 1'b0});

    // R1: asynchronous reset while running
    #2 rst_n = 1'b0;
    #1;
    check({bclk_oe, fs_oe, sdata_oe, bclk, fs, sdata} == 6'b0, "R1 async reset",
          {bclk_oe, fs_oe, sdata_oe, bclk, fs, sdata}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule